// File: doc/BRIEF.md
# SDRAM Mode Register and Read-Latency Pipeline

This block models the device side of a single-data-rate SDRAM, limited to its mode register and its read output timing. A controller issues one of four commands each clock on a 2-bit command input. A load-mode command captures a 10-bit mode word from the address bus. The word sets the burst length, the read latency, the operating mode and whether writes burst or touch one location. A read is followed, after the programmed latency, by a burst of words on the data output. The driver enable switches on one cycle before the first word is valid and switches off after the last word. A small register file indexed by the column address stands in for the storage array.

The DQ bus is split into `dq_i`, `dq_o` and `dq_oe`, so that a pad ring can build the tri-state buffer. Burst sequencing uses two small state machines. The read engine has the states R_IDLE and R_BURST. Its transitions are: R_IDLE→R_BURST when a read token reaches the head of the latency pipeline and the burst is longer than one; R_BURST→R_BURST on a new token (truncation) or while words remain; R_BURST→R_IDLE after the last word, or at once when a legal write is issued. The write engine has the states W_IDLE and W_BURST. Its transitions are: W_IDLE→W_BURST on a legal write whose effective burst is longer than one; W_BURST→W_IDLE after the last word, or when any command other than NOP arrives. A new write in W_BURST restarts the burst.

Top module: `sdrm_top`

## Requirements
- R1: After reset, `dq_oe`, `dq_valid`, `mode_illegal` and `mode_lat_err` are 0, and the mode is burst length 1, latency 2, writes bursting.
- R2: Command codes on `cmd` are 00 NOP, 01 READ, 10 WRITE and 11 LOAD MODE. A LOAD MODE captures the mode word from `addr[9:0]`: bits [2:0] burst code, bits [6:4] latency code, bits [8:7] operating mode, bit 9 write-single.
- R3: Latency code 3'b010 selects 2 and 3'b011 selects 3. For a READ registered at edge n with latency m, the first word is on `dq_o` with `dq_valid`=1 after edge n+m.
- R4: `dq_oe` is 1 after edge n+m-1, one cycle before `dq_valid` rises, and `dq_valid` is never 1 while `dq_oe` is 0.
- R5: Burst code 000, 001, 010 and 011 give 1, 2, 4 and 8 words. Any other burst code gives 1 word.
- R6: Burst columns advance by one and wrap inside the block aligned to the burst length, starting at the column given with the command in `addr[COL_W-1:0]`.
- R7: After the clock edge that ends the last burst word, `dq_oe` and `dq_valid` both return to 0.
- R8: A READ issued during a read burst cuts it short. The new burst's first word is valid at its own latency, and `dq_valid` shows no gap.
- R9: With write-single 0, a WRITE stores `dq_i` at the command edge and on each following NOP edge for the burst length. With write-single 1, only the command edge stores, while reads still burst.
- R10: A LOAD MODE with bits [8:7] nonzero sets `mode_illegal` and leaves the other mode fields unchanged. While `mode_illegal` is 1, READ and WRITE have no effect. A LOAD MODE with bits [8:7] zero clears it.
- R11: A legal LOAD MODE with a latency code other than 010 or 011 sets `mode_lat_err` and keeps the previous latency. A legal load with a valid latency code clears the flag.
- R12: A legal WRITE issued while read data is pending or bursting cancels that read: `dq_oe` and `dq_valid` are 0 after the WRITE edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 2 | Command code |
| addr | input | ADDR_W | Mode word or column address |
| dq_i | input | DW | Write data from the bus |
| dq_o | output | DW | Read data to the bus |
| dq_oe | output | 1 | Output driver enable |
| dq_valid | output | 1 | Read word is valid on `dq_o` |
| mode_illegal | output | 1 | Reserved operating mode loaded |
| mode_lat_err | output | 1 | Reserved latency code loaded |

## Verification
Two functions can act in the same cycle: the last words of a running read burst and the start of a newer read. The newer read's pre-drive enable and its first word land in cycles where the old burst would still be driving. The bench provokes this by issuing a second READ two cycles after the first, with latency 2 and burst length 4. It then checks every cycle that `dq_valid` stays high and that the data switches from the old wrapped column sequence to the new one exactly at the new read's latency. A second overlap comes from a WRITE during a pending read: the bench checks that the bus goes quiet on the very next cycle.

// File: rtl/sdrm_pkg.sv
package sdrm_pkg;
    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRITE = 2'b10,
        CMD_LOAD  = 2'b11
    } sdr_cmd_e;

    typedef enum logic {R_IDLE, R_BURST} rd_state_e;
    typedef enum logic {W_IDLE, W_BURST} wr_state_e;

    localparam int BL_W = 4;
endpackage

// File: rtl/sdrm_mode_reg.sv
module sdrm_mode_reg
    import sdrm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [2:0]      bl_code,
    input  logic [2:0]      cl_code,
    input  logic [1:0]      op_code,
    input  logic            ws_bit,
    output logic [BL_W-1:0] bl_words,
    output logic            cl3,
    output logic            wr_single,
    output logic            op_bad,
    output logic            cl_bad
);
    function automatic logic [BL_W-1:0] decode_bl(input logic [2:0] c);
        unique case (c)
            3'b000:  decode_bl = BL_W'(1);
            3'b001:  decode_bl = BL_W'(2);
            3'b010:  decode_bl = BL_W'(4);
            3'b011:  decode_bl = BL_W'(8);
            default: decode_bl = BL_W'(1);
        endcase
    endfunction

    logic cl_ok;
    assign cl_ok = (cl_code == 3'b010) || (cl_code == 3'b011);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bl_words  <= BL_W'(1);
            cl3       <= 1'b0;
            wr_single <= 1'b0;
            op_bad    <= 1'b0;
            cl_bad    <= 1'b0;
        end else if (load) begin
            if (op_code != 2'b00) begin
                op_bad <= 1'b1;
            end else begin
                op_bad    <= 1'b0;
                bl_words  <= decode_bl(bl_code);
                wr_single <= ws_bit;
                cl_bad    <= !cl_ok;
                if (cl_ok) cl3 <= cl_code[0];
            end
        end
    end
endmodule

// File: rtl/sdrm_store.sv
module sdrm_store #(
    parameter int COL_W = 4,
    parameter int DW    = 16
) (
    input  logic             clk,
    input  logic             we,
    input  logic [COL_W-1:0] waddr,
    input  logic [DW-1:0]    wdata,
    input  logic [COL_W-1:0] raddr,
    output logic [DW-1:0]    rdata
);
    localparam int DEPTH = 1 << COL_W;
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/sdrm_wr_engine.sv
module sdrm_wr_engine
    import sdrm_pkg::*;
#(
    parameter int COL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cmd,
    input  logic             nop,
    input  logic [COL_W-1:0] col,
    input  logic [BL_W-1:0]  bl_w,
    output logic             we,
    output logic [COL_W-1:0] waddr
);
    wr_state_e        state, nstate;
    logic [COL_W-1:0] base, off, n_base, n_off, mask;
    logic [BL_W-1:0]  rem, n_rem;

    assign mask = COL_W'(bl_w - BL_W'(1));

    always_comb begin
        nstate = state;
        n_base = base;
        n_off  = off;
        n_rem  = rem;
        we     = 1'b0;
        waddr  = base | off;
        if (wr_cmd) begin
            we     = 1'b1;
            waddr  = col;
            n_base = col & ~mask;
            n_off  = (col + COL_W'(1)) & mask;
            n_rem  = bl_w - BL_W'(1);
            nstate = (bl_w > BL_W'(1)) ? W_BURST : W_IDLE;
        end else begin
            unique case (state)
                W_IDLE: nstate = W_IDLE;
                W_BURST: begin
                    if (nop) begin
                        we     = 1'b1;
                        n_off  = (off + COL_W'(1)) & mask;
                        n_rem  = rem - BL_W'(1);
                        nstate = (rem == BL_W'(1)) ? W_IDLE : W_BURST;
                    end else begin
                        nstate = W_IDLE;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= W_IDLE;
        else        state <= nstate;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base <= '0;
            off  <= '0;
            rem  <= '0;
        end else begin
            base <= n_base;
            off  <= n_off;
            rem  <= n_rem;
        end
    end
endmodule

// File: rtl/sdrm_rd_engine.sv
module sdrm_rd_engine
    import sdrm_pkg::*;
#(
    parameter int COL_W = 4,
    parameter int DW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic [COL_W-1:0] issue_col,
    input  logic             kill,
    input  logic             cl3,
    input  logic [BL_W-1:0]  bl,
    input  logic [DW-1:0]    rd_data,
    output logic [COL_W-1:0] rd_addr,
    output logic [DW-1:0]    dq_o,
    output logic             dq_valid,
    output logic             dq_oe
);
    localparam int STAGES = 3;

    rd_state_e        state, nstate;
    logic [STAGES-1:0] pv;
    logic [COL_W-1:0] pc [STAGES];
    logic [COL_W-1:0] base, off, n_base, n_off, mask, tcol;
    logic [BL_W-1:0]  rem, n_rem;
    logic             tok, pre, n_valid;

    assign tok  = cl3 ? pv[2] : pv[1];
    assign tcol = cl3 ? pc[2] : pc[1];
    assign pre  = cl3 ? pv[1] : pv[0];
    assign mask = COL_W'(bl - BL_W'(1));

    always_comb begin
        nstate  = state;
        n_base  = base;
        n_off   = off;
        n_rem   = rem;
        n_valid = 1'b0;
        rd_addr = base | off;
        if (tok) begin
            rd_addr = tcol;
            n_valid = 1'b1;
            n_base  = tcol & ~mask;
            n_off   = (tcol + COL_W'(1)) & mask;
            n_rem   = bl - BL_W'(1);
            nstate  = (bl > BL_W'(1)) ? R_BURST : R_IDLE;
        end else begin
            unique case (state)
                R_IDLE: nstate = R_IDLE;
                R_BURST: begin
                    n_valid = 1'b1;
                    n_off   = (off + COL_W'(1)) & mask;
                    n_rem   = rem - BL_W'(1);
                    nstate  = (rem == BL_W'(1)) ? R_IDLE : R_BURST;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || kill) state <= R_IDLE;
        else                state <= nstate;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pv       <= '0;
            base     <= '0;
            off      <= '0;
            rem      <= '0;
            dq_o     <= '0;
            dq_valid <= 1'b0;
            dq_oe    <= 1'b0;
        end else begin
            pv       <= kill ? '0 : {pv[STAGES-2:0], issue};
            base     <= n_base;
            off      <= n_off;
            rem      <= n_rem;
            if (n_valid) dq_o <= rd_data;
            dq_valid <= n_valid && !kill;
            dq_oe    <= (n_valid || pre) && !kill;
        end
    end

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_col_pipe
            always_ff @(posedge clk) begin
                if (!rst_n)  pc[s] <= '0;
                else if (s == 0) pc[s] <= issue_col;
                else         pc[s] <= pc[s-1];
            end
        end
    endgenerate
endmodule

// File: rtl/sdrm_top.sv
module sdrm_top
    import sdrm_pkg::*;
#(
    parameter int COL_W  = 4,
    parameter int DW     = 16,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     dq_i,
    output logic [DW-1:0]     dq_o,
    output logic              dq_oe,
    output logic              dq_valid,
    output logic              mode_illegal,
    output logic              mode_lat_err
);
    sdr_cmd_e         c;
    logic [BL_W-1:0]  bl_words, bl_w;
    logic             cl3, wr_single;
    logic             rd_go, wr_go, we;
    logic [COL_W-1:0] waddr, raddr;
    logic [DW-1:0]    rdata;

    assign c     = sdr_cmd_e'(cmd);
    assign rd_go = (c == CMD_READ)  && !mode_illegal;
    assign wr_go = (c == CMD_WRITE) && !mode_illegal;
    assign bl_w  = wr_single ? BL_W'(1) : bl_words;

    sdrm_mode_reg u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (c == CMD_LOAD),
        .bl_code  (addr[2:0]),
        .cl_code  (addr[6:4]),
        .op_code  (addr[8:7]),
        .ws_bit   (addr[9]),
        .bl_words (bl_words),
        .cl3      (cl3),
        .wr_single(wr_single),
        .op_bad   (mode_illegal),
        .cl_bad   (mode_lat_err)
    );

    sdrm_wr_engine #(.COL_W(COL_W)) u_wr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_cmd(wr_go),
        .nop   (c == CMD_NOP),
        .col   (addr[COL_W-1:0]),
        .bl_w  (bl_w),
        .we    (we),
        .waddr (waddr)
    );

    sdrm_store #(.COL_W(COL_W), .DW(DW)) u_store (
        .clk  (clk),
        .we   (we),
        .waddr(waddr),
        .wdata(dq_i),
        .raddr(raddr),
        .rdata(rdata)
    );

    sdrm_rd_engine #(.COL_W(COL_W), .DW(DW)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (rd_go),
        .issue_col(addr[COL_W-1:0]),
        .kill     (wr_go),
        .cl3      (cl3),
        .bl       (bl_words),
        .rd_data  (rdata),
        .rd_addr  (raddr),
        .dq_o     (dq_o),
        .dq_valid (dq_valid),
        .dq_oe    (dq_oe)
    );
endmodule

// File: rtl/sdrm_checker.sv
module sdrm_checker #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cmd,
    input logic [ADDR_W-1:0] addr,
    input logic              dq_oe,
    input logic              dq_valid,
    input logic              mode_illegal,
    input logic              mode_lat_err
);
    // R4: data is never valid while the driver is off
    a_r4_valid_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
        dq_valid |-> dq_oe);

    // R4: driver was already on the cycle before valid rose
    a_r4_oe_leads_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_valid) |-> $past(dq_oe));

    // R10: reserved operating mode raises the flag
    a_r10_illegal_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'b11 && addr[8:7] != 2'b00) |=> mode_illegal);

    // R10: only a load can change the flag
    a_r10_illegal_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != 2'b11) |=> $stable(mode_illegal));

    // R11: reserved latency code under a legal mode raises the error flag
    a_r11_lat_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'b11 && addr[8:7] == 2'b00 && addr[6:4] != 3'b010 && addr[6:4] != 3'b011)
        |=> mode_lat_err);

    // R12: a legal write silences the bus on the next cycle
    a_r12_write_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'b10 && !mode_illegal) |=> (!dq_oe && !dq_valid));
endmodule

bind sdrm_top sdrm_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd         (cmd),
    .addr        (addr),
    .dq_oe       (dq_oe),
    .dq_valid    (dq_valid),
    .mode_illegal(mode_illegal),
    .mode_lat_err(mode_lat_err)
);

// File: tb/sdrm_top_tb.sv
module sdrm_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int COL_W = 4;
    localparam int DW = 16;
    localparam int ADDR_W = 10;
    localparam int NCOL = 1 << COL_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        cmd = 2'b00;
    logic [ADDR_W-1:0] addr = '0;
    logic [DW-1:0]     dq_i = '0;
    logic [DW-1:0]     dq_o;
    logic              dq_oe, dq_valid, mode_illegal, mode_lat_err;

    int n_chk = 0;
    int n_bad = 0;
    logic [DW-1:0] mm [NCOL];

    always #(CLK_PERIOD/2) clk = ~clk;

    sdrm_top #(.COL_W(COL_W), .DW(DW), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .addr(addr), .dq_i(dq_i),
        .dq_o(dq_o), .dq_oe(dq_oe), .dq_valid(dq_valid),
        .mode_illegal(mode_illegal), .mode_lat_err(mode_lat_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [9:0] mword(input int cl, input int blc, input bit ws);
        return {ws, 2'b00, 3'(cl), 1'b0, 3'(blc)};
    endfunction

    task automatic load(input logic [9:0] w);
        cmd = 2'b11; addr = w; tick(); cmd = 2'b00;
    endtask

    task automatic wr1(input int col, input logic [DW-1:0] d);
        cmd = 2'b10; addr = ADDR_W'(col); dq_i = d; tick(); cmd = 2'b00;
        mm[col] = d;
    endtask

    // Issue READ, then check every cycle from edge n to edge n+m+bl+1
    task automatic rd_check(input string req, input int col, input int m, input int bl);
        cmd = 2'b01; addr = ADDR_W'(col); tick(); cmd = 2'b00;
        for (int t = 0; t <= m + bl + 1; t++) begin
            bit eo, ev;
            int idx, c;
            if (t > 0) tick();
            eo = (t >= m - 1) && (t <= m + bl - 1);
            ev = (t >= m) && (t <= m + bl - 1);
            chk({req, " oe"}, 32'(dq_oe), 32'(eo));
            chk({req, " valid"}, 32'(dq_valid), 32'(ev));
            if (ev) begin
                idx = t - m;
                c = (col & ~(bl - 1)) | ((col + idx) & (bl - 1));
                chk({req, " data"}, 32'(dq_o), 32'(mm[c]));
            end
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 oe", 32'(dq_oe), 0);
        chk("R1 valid", 32'(dq_valid), 0);
        chk("R1 illegal", 32'(mode_illegal), 0);
        chk("R1 laterr", 32'(mode_lat_err), 0);

        // Preload under reset mode (single-word writes)
        for (int i = 0; i < NCOL; i++) wr1(i, 16'h1000 + 16'(i * 37));
        rd_check("R1 default mode", 3, 2, 1);

        // R2 R3 R4 R5 R6 R7: sweep latency, burst length, start column
        for (int cl = 2; cl <= 3; cl++)
            for (int blc = 0; blc < 4; blc++)
                for (int col = 0; col < NCOL; col++) begin
                    load(mword(cl, blc, 1'b0));
                    rd_check("R3 R4 R6 R7 sweep", col, cl, 1 << blc);
                end

        // R5: reserved burst code gives one word
        load(mword(2, 5, 1'b0));
        rd_check("R5 reserved bl", 6, 2, 1);
        load(mword(3, 7, 1'b0));
        rd_check("R5 reserved bl", 9, 3, 1);

        // R8: second READ two cycles after the first
        load(mword(2, 2, 1'b0));
        begin
            int ecol [8];
            ecol = '{0, 0, 1, 2, 10, 11, 8, 9};
            cmd = 2'b01; addr = 10'd1; tick();
            cmd = 2'b00; tick();
            cmd = 2'b01; addr = 10'd10;
            for (int t = 2; t <= 9; t++) begin
                tick();
                cmd = 2'b00;
                if (t <= 7) begin
                    chk("R8 valid", 32'(dq_valid), 1);
                    chk("R8 oe", 32'(dq_oe), 1);
                    chk("R8 data", 32'(dq_o), 32'(mm[ecol[t]]));
                end else begin
                    chk("R8 end oe", 32'(dq_oe), 0);
                    chk("R8 end valid", 32'(dq_valid), 0);
                end
            end
        end

        // R9: burst write of 4 words from column 5
        load(mword(2, 2, 1'b0));
        cmd = 2'b10; addr = 10'd5; dq_i = 16'hB000; tick();
        cmd = 2'b00; dq_i = 16'hB001; tick();
        dq_i = 16'hB002; tick();
        dq_i = 16'hB003; tick();
        dq_i = 16'hB0FF; tick();
        mm[5] = 16'hB000; mm[6] = 16'hB001; mm[7] = 16'hB002; mm[4] = 16'hB003;
        rd_check("R9 R6 burst write", 4, 2, 4);

        // R9: write-single, reads still burst
        load(mword(2, 2, 1'b1));
        cmd = 2'b10; addr = 10'd9; dq_i = 16'hC000; tick();
        cmd = 2'b00; dq_i = 16'hC001; tick();
        dq_i = 16'hC002; tick();
        dq_i = 16'hC003; tick();
        mm[9] = 16'hC000;
        rd_check("R9 single write", 8, 2, 4);

        // R10: reserved operating mode
        load(10'b0_01_010_0_010);
        chk("R10 flag set", 32'(mode_illegal), 1);
        cmd = 2'b01; addr = 10'd2; tick(); cmd = 2'b00;
        for (int t = 0; t < 6; t++) begin
            chk("R10 read ignored oe", 32'(dq_oe), 0);
            chk("R10 read ignored valid", 32'(dq_valid), 0);
            tick();
        end
        cmd = 2'b10; addr = 10'd2; dq_i = 16'hDEAD; tick(); cmd = 2'b00;
        load(mword(2, 0, 1'b0));
        chk("R10 flag cleared", 32'(mode_illegal), 0);
        rd_check("R10 write ignored", 2, 2, 1);

        // R11: reserved latency keeps latency 3
        load(mword(3, 0, 1'b0));
        load(mword(6, 0, 1'b0));
        chk("R11 err set", 32'(mode_lat_err), 1);
        rd_check("R11 latency kept", 0, 3, 1);
        load(mword(2, 0, 1'b0));
        chk("R11 err cleared", 32'(mode_lat_err), 0);

        // R12: write cancels an active read burst
        load(mword(2, 3, 1'b1));
        cmd = 2'b01; addr = 10'd0; tick();
        cmd = 2'b00; tick(); tick();
        chk("R12 burst active", 32'(dq_valid), 1);
        cmd = 2'b10; addr = 10'd15; dq_i = 16'h00EE; tick();
        cmd = 2'b00; mm[15] = 16'h00EE;
        chk("R12 oe off", 32'(dq_oe), 0);
        chk("R12 valid off", 32'(dq_valid), 0);
        tick();
        chk("R12 stays off", 32'(dq_oe), 0);
        rd_check("R12 R6 readback", 15, 2, 8);

        finish_run();
    end
endmodule